// File: doc/BRIEF.md
# Issue Window Tag Wakeup

This block keeps a small pool of instructions that wait for their source operands. Each waiting entry holds two source physical-register tags, and each tag has its own ready flag. On every cycle the writeback path announces up to a fixed number of result tags on parallel broadcast lanes. The announcement comes early, ahead of the result itself, so a dependent instruction can issue right behind its producer. Every stored tag is compared with every valid lane, and a hit on any lane sets that operand's ready flag.

An entry with both operands ready raises its bit in an issue request vector. A separate select block reads that vector and answers with grants, and a granted entry is freed on the following edge. Dispatch writes one instruction per cycle into the lowest-numbered free entry. If a source tag is being broadcast in the same cycle as dispatch, or if the instruction has no register source, that operand starts out ready. Operand values are not stored here.

Top module: `wake_window`

## Requirements
- R1: After reset, no entry is occupied, the request vector is zero, `win_full` is low and `disp_slot` is 0.
- R2: With `disp_valid` high and `win_full` low, the instruction is written into the entry that `disp_slot` names, and that entry's bit in `entry_valid` is set after the next rising edge.
- R3: An occupied entry's operand becomes ready at the next edge if its tag equals the tag on any broadcast lane whose `bc_valid` bit is high. Lane l carries its tag in `bc_tag[l*TAG_W +: TAG_W]`. Lanes whose valid bit is low are ignored. Once set, a ready flag stays set until the entry is released.
- R4: `req[i]` is high exactly when entry i is occupied and both of its operands are ready. An entry with only one ready operand does not request.
- R5: A source whose `*_used` input is low at dispatch is stored as ready.
- R6: A used source whose tag matches a valid broadcast lane in the dispatch cycle is stored as ready, so the entry can request in the first cycle after allocation.
- R7: A grant on a requesting entry clears that entry's occupied bit at the next edge. A grant on an entry that is not requesting has no effect.
- R8: `win_full` is high while all entries are occupied. A dispatch presented while the window is full is dropped and leaves every entry unchanged.
- R9: `disp_slot` always names the lowest-numbered unoccupied entry, so an entry freed by a grant can be used again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch an instruction this cycle |
| disp_src0_tag | input | TAG_W | Physical tag of the first source |
| disp_src0_used | input | 1 | First source reads a register |
| disp_src1_tag | input | TAG_W | Physical tag of the second source |
| disp_src1_used | input | 1 | Second source reads a register |
| disp_slot | output | $clog2(ENTRIES) | Entry that the next dispatch will fill |
| win_full | output | 1 | No free entry |
| bc_valid | input | BCAST | Valid bit for each broadcast lane |
| bc_tag | input | BCAST*TAG_W | Broadcast tags, lane l at bits l*TAG_W and up |
| grant | input | ENTRIES | Grants from the select block |
| req | output | ENTRIES | Issue request for each entry |
| entry_valid | output | ENTRIES | Occupied flag for each entry |

## Verification
Two events can land in the same cycle and are tested that way. The first is a dispatch whose source tags are on the broadcast lanes in that same cycle. The check is that the entry requests in the first cycle after allocation, and that a partial match leaves it waiting. The second is a grant to one entry while a broadcast wakes a different entry. The check is that the release and the wakeup both take effect at the same edge. A third overlap combines a dropped dispatch with a full window. It is judged by confirming that the request vector stays clear, since an overwrite with unused sources would have raised a request.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int unsigned WK_ENTRIES = 16;
   localparam int unsigned WK_BCAST   = 4;
   localparam int unsigned WK_TAG_W   = 6;
   localparam int unsigned WK_NSRC    = 2;
endpackage

// File: rtl/wake_cmp.sv
module wake_cmp #(
   parameter int unsigned TAG_W = 6,
   parameter int unsigned BCAST = 4
) (
   input  logic [TAG_W-1:0]       tag,
   input  logic [BCAST-1:0]       bc_valid,
   input  logic [BCAST*TAG_W-1:0] bc_tag,
   output logic                   hit
);
   logic [BCAST-1:0] lane_hit;

   for (genvar l = 0; l < BCAST; l++) begin : g_lane
      assign lane_hit[l] = bc_valid[l] && (bc_tag[l*TAG_W +: TAG_W] == tag);
   end

   assign hit = |lane_hit;
endmodule

// File: rtl/wake_slot.sv
module wake_slot
   import wake_pkg::*;
#(
   parameter int unsigned TAG_W = 6,
   parameter int unsigned BCAST = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [WK_NSRC-1:0][TAG_W-1:0]  wr_tag,
   input  logic [WK_NSRC-1:0]             wr_use,
   input  logic [BCAST-1:0]               bc_valid,
   input  logic [BCAST*TAG_W-1:0]         bc_tag,
   input  logic                           grant,
   output logic                           vld,
   output logic                           req
);
   logic               vld_q;
   logic [WK_NSRC-1:0] rdy_v;

   for (genvar k = 0; k < WK_NSRC; k++) begin : g_op
      logic [TAG_W-1:0] tag_q;
      logic             rdy_q;
      logic [TAG_W-1:0] cmp_tag;
      logic             hit;

      // one comparator row serves both dispatch and wakeup
      assign cmp_tag = wr_en ? wr_tag[k] : tag_q;

      wake_cmp #(.TAG_W(TAG_W), .BCAST(BCAST)) u_cmp (
         .tag      (cmp_tag),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .hit      (hit)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q <= '0;
            rdy_q <= 1'b0;
         end else if (wr_en) begin
            tag_q <= wr_tag[k];
            rdy_q <= !wr_use[k] || hit;
         end else if (vld_q) begin
            rdy_q <= rdy_q || hit;
         end
      end

      assign rdy_v[k] = rdy_q;
   end

   assign req = vld_q && (&rdy_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            vld_q <= 1'b0;
      else if (wr_en)        vld_q <= 1'b1;
      else if (grant && req) vld_q <= 1'b0;
   end

   assign vld = vld_q;
endmodule

// File: rtl/wake_pick.sv
module wake_pick #(
   parameter int unsigned N = 16,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     free,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free[i]) idx = IDX_W'(i);
      end
   end

   assign any = |free;
endmodule

// File: rtl/wake_window.sv
module wake_window
   import wake_pkg::*;
#(
   parameter int unsigned ENTRIES = WK_ENTRIES,
   parameter int unsigned BCAST   = WK_BCAST,
   parameter int unsigned TAG_W   = WK_TAG_W,
   localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   disp_valid,
   input  logic [TAG_W-1:0]       disp_src0_tag,
   input  logic                   disp_src0_used,
   input  logic [TAG_W-1:0]       disp_src1_tag,
   input  logic                   disp_src1_used,
   output logic [SLOT_W-1:0]      disp_slot,
   output logic                   win_full,
   input  logic [BCAST-1:0]       bc_valid,
   input  logic [BCAST*TAG_W-1:0] bc_tag,
   input  logic [ENTRIES-1:0]     grant,
   output logic [ENTRIES-1:0]     req,
   output logic [ENTRIES-1:0]     entry_valid
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("wake_window: ENTRIES must be at least 2");
   end
   if (BCAST < 1) begin : g_bad_bcast
      $error("wake_window: BCAST must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wake_window: TAG_W must be at least 1");
   end

   logic [WK_NSRC-1:0][TAG_W-1:0] wr_tag;
   logic [WK_NSRC-1:0]            wr_use;
   logic [ENTRIES-1:0]            vld_v;
   logic                          free_any;

   assign wr_tag = {disp_src1_tag, disp_src0_tag};
   assign wr_use = {disp_src1_used, disp_src0_used};

   wake_pick #(.N(ENTRIES)) u_pick (
      .free (~vld_v),
      .any  (free_any),
      .idx  (disp_slot)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic wr_en;
      assign wr_en = disp_valid && free_any && (disp_slot == SLOT_W'(i));

      wake_slot #(.TAG_W(TAG_W), .BCAST(BCAST)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en),
         .wr_tag   (wr_tag),
         .wr_use   (wr_use),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .grant    (grant[i]),
         .vld      (vld_v[i]),
         .req      (req[i])
      );
   end

   assign win_full    = !free_any;
   assign entry_valid = vld_v;
endmodule

// File: rtl/wake_window_chk.sv
module wake_window_chk #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned BCAST   = 4,
   parameter int unsigned TAG_W   = 6,
   localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   disp_valid,
   input logic [SLOT_W-1:0]      disp_slot,
   input logic                   win_full,
   input logic [BCAST-1:0]       bc_valid,
   input logic [ENTRIES-1:0]     grant,
   input logic [ENTRIES-1:0]     req,
   input logic [ENTRIES-1:0]     entry_valid
);
   p_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !win_full |=> entry_valid[$past(disp_slot)]);

   p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      win_full && disp_valid && (grant == '0) |=> entry_valid == $past(entry_valid));

   p_slot_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !win_full |-> !entry_valid[disp_slot]);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
      p_req_occupied_r4: assert property (@(posedge clk) disable iff (!rst_n)
         req[i] |-> entry_valid[i]);

      p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] && req[i] |=> !entry_valid[i]);

      p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
         req[i] && !grant[i] |=> req[i]);
   end
endmodule

bind wake_window wake_window_chk #(
   .ENTRIES (ENTRIES),
   .BCAST   (BCAST),
   .TAG_W   (TAG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .disp_valid  (disp_valid),
   .disp_slot   (disp_slot),
   .win_full    (win_full),
   .bc_valid    (bc_valid),
   .grant       (grant),
   .req         (req),
   .entry_valid (entry_valid)
);

// File: tb/sim_wake_window.sv
module sim_wake_window;
   localparam int CLK_PERIOD = 10;
   localparam int EN = 16;
   localparam int BC = 4;
   localparam int TW = 6;
   localparam int SW = $clog2(EN);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           disp_valid;
   logic [TW-1:0]  disp_src0_tag, disp_src1_tag;
   logic           disp_src0_used, disp_src1_used;
   logic [SW-1:0]  disp_slot;
   logic           win_full;
   logic [BC-1:0]  bc_valid;
   logic [BC*TW-1:0] bc_tag;
   logic [EN-1:0]  grant, req, entry_valid;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wake_window #(.ENTRIES(EN), .BCAST(BC), .TAG_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
      .disp_src0_tag(disp_src0_tag), .disp_src0_used(disp_src0_used),
      .disp_src1_tag(disp_src1_tag), .disp_src1_used(disp_src1_used),
      .disp_slot(disp_slot), .win_full(win_full),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .grant(grant),
      .req(req), .entry_valid(entry_valid)
   );

   task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic clr();
      disp_valid = 0; disp_src0_tag = '0; disp_src0_used = 0;
      disp_src1_tag = '0; disp_src1_used = 0;
      bc_valid = '0; bc_tag = '0; grant = '0;
   endtask

   task automatic tick();
      @(posedge clk); #1; clr();
   endtask

   task automatic disp(int t0, bit u0_, int t1, bit u1_);
      disp_valid = 1;
      disp_src0_tag = TW'(t0); disp_src0_used = u0_;
      disp_src1_tag = TW'(t1); disp_src1_used = u1_;
   endtask

   task automatic bc(int lane, int tag);
      bc_valid[lane] = 1'b1;
      bc_tag[lane*TW +: TW] = TW'(tag);
   endtask

   task automatic do_reset();
      clr();
      rst_n = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", "entry_valid", entry_valid, 0);
      check("R1", "req", req, 0);
      check("R1", "win_full", win_full, 0);
      check("R1", "disp_slot", disp_slot, 0);
   endtask

   task automatic t_alloc_wake();
      do_reset();
      disp(5, 1, 6, 1); tick();
      check("R2", "valid after first dispatch", entry_valid, 16'h0001);
      check("R2", "next slot", disp_slot, 1);
      check("R4", "no req without ready", req, 0);
      disp(7, 1, 8, 1); tick();
      check("R2", "valid after second dispatch", entry_valid, 16'h0003);
      bc(2, 5); tick();
      check("R4", "one operand ready only", req, 0);
      bc(3, 6); bc_tag[0 +: TW] = TW'(7); tick();
      check("R3", "lane3 wakes, invalid lane0 ignored", req, 16'h0001);
      bc(1, 7); bc(0, 8); tick();
      check("R3", "two lanes wake both operands", req, 16'h0003);
      tick();
      check("R3", "ready stays set", req, 16'h0003);
   endtask

   task automatic t_unused();
      do_reset();
      disp(0, 0, 0, 0); tick();
      check("R5", "no sources requests at once", req, 16'h0001);
      disp(0, 0, 9, 1); tick();
      check("R5", "one used source waits", req, 16'h0001);
      bc(3, 9); tick();
      check("R5", "used source woken", req, 16'h0003);
   endtask

   task automatic t_same_cycle();
      do_reset();
      disp(10, 1, 11, 1); bc(0, 10); bc(3, 11); tick();
      check("R6", "both tags broadcast at dispatch", req, 16'h0001);
      disp(12, 1, 13, 1); bc(2, 12); tick();
      check("R6", "partial match at dispatch", req, 16'h0001);
      bc(1, 13); tick();
      check("R6", "remaining operand woken", req, 16'h0003);
   endtask

   task automatic t_grant();
      do_reset();
      disp(0, 0, 0, 0); tick();
      disp(0, 0, 0, 0); tick();
      check("R7", "two requesting", req, 16'h0003);
      grant[0] = 1; grant[3] = 1; tick();
      check("R7", "grant frees entry 0, empty grant ignored", entry_valid, 16'h0002);
      disp(30, 1, 31, 1); tick();
      check("R9", "freed entry 0 reused", entry_valid, 16'h0003);
      grant[0] = 1; tick();
      check("R7", "grant on waiting entry ignored", entry_valid, 16'h0003);
      grant[1] = 1; bc(0, 30); bc(1, 31); tick();
      check("R7", "release and wakeup same edge valid", entry_valid, 16'h0001);
      check("R7", "release and wakeup same edge req", req, 16'h0001);
   endtask

   task automatic t_full();
      do_reset();
      for (int i = 0; i < EN; i++) begin
         disp(20, 1, 21, 1); tick();
      end
      check("R8", "full flag", win_full, 1);
      check("R8", "all occupied", entry_valid, 16'hFFFF);
      disp(0, 0, 0, 0); tick();
      check("R8", "dropped dispatch leaves req clear", req, 0);
      bc(0, 20); bc(1, 21); tick();
      check("R3", "all entries woken", req, 16'hFFFF);
      grant[9] = 1; grant[5] = 1; tick();
      check("R7", "two released", entry_valid, 16'hFDDF);
      check("R8", "not full", win_full, 0);
      check("R9", "lowest free slot", disp_slot, 5);
      disp(0, 0, 0, 0); tick();
      check("R9", "slot 5 refilled", entry_valid, 16'hFDFF);
      check("R9", "next slot 9", disp_slot, 9);
   endtask

   initial begin
      clr();
      t_reset();
      t_alloc_wake();
      t_unused();
      t_same_cycle();
      t_grant();
      t_full();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule